// File: doc/BRIEF.md
# Operating Mode Clock Controller

This block sets the power mode of a small 8-bit microcontroller. It runs in one of three modes. In Normal the core is clocked by the fast internal RC oscillator. In Slow it is clocked by a low-frequency watch crystal. In Sleep, program execution is stopped. Its inputs are a static code for the oscillator option, a clock-mode bit written by software, a one-cycle halt strobe from the instruction decoder, a wake-up event, and the clock source chosen for the watchdog. Its outputs are the enables for the fast and slow oscillators, the system-clock select, the current mode, and the clear and run controls of the watchdog counter.

The clock-mode bit has an effect only with the internal-RC-plus-crystal option. Every other option keeps the core on the fast clock and keeps the crystal disabled. Halt always wins, and it always stops the fast oscillator. The crystal runs on through Sleep. Any change of the clock select happens at a register boundary, and the fast oscillator is always enabled at least one cycle before the select leaves the crystal. The block never asserts a reset on Sleep entry, so core state is retained.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In Normal (mode code 0), hfOscEn is 1 and sysClkSelLf is 0.
- R2: When oscCfg equals 3 (internal RC plus crystal) and clkModeSlow is 1 in Normal, the next edge gives Slow (mode code 1): sysClkSelLf 1 and hfOscEn 0. With any other oscCfg, clkModeSlow has no effect and the block stays in Normal.
- R3: lfOscEn follows oscCfg==3 with one cycle of latency, and it is 0 for any other code.
- R4: haltStrobe in Normal or Slow gives Sleep (mode code 2) with hfOscEn 0 at the next edge. It takes priority over a clock-mode change in the same cycle.
- R5: Through Sleep, sysClkSelLf holds its value from before Sleep, and lfOscEn stays 1 when oscCfg is 3.
- R6: Sleep entry gives a one-cycle wdtClear pulse. wdtRun then holds the value wdtSrcIndep had at entry (1 = watchdog on its own or crystal clock, 0 = on the system clock) until wake. Outside Sleep, wdtRun is 1.
- R7: haltStrobe in Sleep is ignored: no wdtClear pulse and no change of mode.
- R8: A wake event in Sleep raises hfOscEn at the next edge while the mode stays Sleep. One edge later the block enters Slow if oscCfg==3 and clkModeSlow were 1 in the wake cycle, and Normal otherwise.
- R9: Leaving Slow for Normal takes two edges: hfOscEn rises first, then sysClkSelLf falls and the mode becomes Normal. sysClkSelLf never falls unless hfOscEn was 1 in the previous cycle.
- R10: While rstN is low: mode Normal, hfOscEn 1, sysClkSelLf 0, lfOscEn 0, wdtClear 1, wdtRun 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscCfg | input | 2 | Oscillator option code; 3 = internal RC plus crystal |
| clkModeSlow | input | 1 | Software request for the crystal as system clock |
| haltStrobe | input | 1 | Halt instruction executed |
| wakeEvent | input | 1 | Wake-up event |
| wdtSrcIndep | input | 1 | Watchdog clocked independently of the system clock |
| hfOscEn | output | 1 | Fast oscillator enable |
| lfOscEn | output | 1 | Crystal oscillator enable |
| sysClkSelLf | output | 1 | System clock from the crystal |
| modeOut | output | 2 | 0 Normal, 1 Slow, 2 Sleep |
| wdtClear | output | 1 | Watchdog clear |
| wdtRun | output | 1 | Watchdog count enable |

## Verification
The bench builds the block with its default parameters: a two-bit option code, with code 3 as the crystal-capable option. At this width every option can be driven. Code 0 shows that the clock-mode bit is inert and the crystal stays off, code 1 runs a halt and wake without the crystal, and code 3 reaches every mode transition, including halt during the two-step return from Slow and a clock-mode change made while asleep.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLOW   = 2'd1,
    MODE_SLEEP  = 2'd2
  } modeE;

  // strobes from the control FSM to the output datapath
  typedef struct packed {
    logic enterSleep;
    logic toSlow;
    logic toNormal;
    logic hfPreStart;
  } modeStrobesT;
endpackage

// File: rtl/pwr_mode_ctrl_fsm.sv
module pwr_mode_ctrl_fsm
  import pwr_mode_pkg::*;
#(
  parameter int CfgW = 2,
  parameter logic [CfgW-1:0] LfCfgCode = {CfgW{1'b1}}
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CfgW-1:0] oscCfg,
  input  logic            clkModeSlow,
  input  logic            haltStrobe,
  input  logic            wakeEvent,
  output modeStrobesT     strobes
);
  typedef enum logic [2:0] {
    ST_NORMAL, ST_SLOW, ST_TO_NORMAL, ST_SLEEP, ST_WAKE
  } stateE;

  stateE stateQ, stateD;
  logic  targetSlowQ, targetSlowD;
  logic  slowReq;

  always_comb slowReq = (oscCfg == LfCfgCode) && clkModeSlow;

  always_comb begin
    stateD      = stateQ;
    targetSlowD = targetSlowQ;
    strobes     = '0;
    unique case (stateQ)
      ST_NORMAL: begin
        if (haltStrobe) begin
          stateD = ST_SLEEP;
          strobes.enterSleep = 1'b1;
        end else if (slowReq) begin
          stateD = ST_SLOW;
          strobes.toSlow = 1'b1;
        end
      end
      ST_SLOW: begin
        if (haltStrobe) begin
          stateD = ST_SLEEP;
          strobes.enterSleep = 1'b1;
        end else if (!slowReq) begin
          stateD = ST_TO_NORMAL;
          strobes.hfPreStart = 1'b1;
        end
      end
      ST_TO_NORMAL: begin
        if (haltStrobe) begin
          stateD = ST_SLEEP;
          strobes.enterSleep = 1'b1;
        end else begin
          stateD = ST_NORMAL;
          strobes.toNormal = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wakeEvent) begin
          stateD      = ST_WAKE;
          targetSlowD = slowReq;
          strobes.hfPreStart = 1'b1;
        end
      end
      ST_WAKE: begin
        stateD = targetSlowQ ? ST_SLOW : ST_NORMAL;
        strobes.toSlow   = targetSlowQ;
        strobes.toNormal = !targetSlowQ;
      end
      default: stateD = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_NORMAL;
      targetSlowQ <= 1'b0;
    end else begin
      stateQ      <= stateD;
      targetSlowQ <= targetSlowD;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl_dp.sv
module pwr_mode_ctrl_dp
  import pwr_mode_pkg::*;
#(
  parameter int CfgW = 2,
  parameter logic [CfgW-1:0] LfCfgCode = {CfgW{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeStrobesT       strobes,
  input  logic [CfgW-1:0]   oscCfg,
  input  logic              wdtSrcIndep,
  output logic              hfOscEn,
  output logic              lfOscEn,
  output logic              sysClkSelLf,
  output logic [MODE_W-1:0] modeOut,
  output logic              wdtClear,
  output logic              wdtRun
);
  modeE modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hfOscEn     <= 1'b1;
      lfOscEn     <= 1'b0;
      sysClkSelLf <= 1'b0;
      modeQ       <= MODE_NORMAL;
      wdtClear    <= 1'b1;
      wdtRun      <= 1'b1;
    end else begin
      lfOscEn  <= (oscCfg == LfCfgCode);
      wdtClear <= strobes.enterSleep;
      if (strobes.enterSleep) begin
        hfOscEn <= 1'b0;
        modeQ   <= MODE_SLEEP;
        wdtRun  <= wdtSrcIndep;
      end else if (strobes.toSlow) begin
        hfOscEn     <= 1'b0;
        sysClkSelLf <= 1'b1;
        modeQ       <= MODE_SLOW;
        wdtRun      <= 1'b1;
      end else if (strobes.toNormal) begin
        hfOscEn     <= 1'b1;
        sysClkSelLf <= 1'b0;
        modeQ       <= MODE_NORMAL;
        wdtRun      <= 1'b1;
      end else if (strobes.hfPreStart) begin
        hfOscEn <= 1'b1;
      end
    end
  end

  always_comb modeOut = modeQ;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CfgW = 2,
  parameter logic [CfgW-1:0] LfCfgCode = {CfgW{1'b1}}
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CfgW-1:0] oscCfg,
  input  logic            clkModeSlow,
  input  logic            haltStrobe,
  input  logic            wakeEvent,
  input  logic            wdtSrcIndep,
  output logic            hfOscEn,
  output logic            lfOscEn,
  output logic            sysClkSelLf,
  output logic [1:0]      modeOut,
  output logic            wdtClear,
  output logic            wdtRun
);
  modeStrobesT strobes;

  pwr_mode_ctrl_fsm #(.CfgW(CfgW), .LfCfgCode(LfCfgCode)) fsm_i (
    .clk(clk), .rstN(rstN), .oscCfg(oscCfg), .clkModeSlow(clkModeSlow),
    .haltStrobe(haltStrobe), .wakeEvent(wakeEvent), .strobes(strobes)
  );

  pwr_mode_ctrl_dp #(.CfgW(CfgW), .LfCfgCode(LfCfgCode)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .oscCfg(oscCfg),
    .wdtSrcIndep(wdtSrcIndep), .hfOscEn(hfOscEn), .lfOscEn(lfOscEn),
    .sysClkSelLf(sysClkSelLf), .modeOut(modeOut), .wdtClear(wdtClear),
    .wdtRun(wdtRun)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int CfgW = 2,
  parameter logic [CfgW-1:0] LfCfgCode = {CfgW{1'b1}}
) (
  input logic            clk,
  input logic            rstN,
  input logic [CfgW-1:0] oscCfg,
  input logic            haltStrobe,
  input logic            wakeEvent,
  input logic            wdtSrcIndep,
  input logic            hfOscEn,
  input logic            lfOscEn,
  input logic            sysClkSelLf,
  input logic [1:0]      modeOut,
  input logic            wdtClear,
  input logic            wdtRun
);
  localparam logic [1:0] CodeNormal = 2'd0;
  localparam logic [1:0] CodeSleep  = 2'd2;

  p_normal_on_hf_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == CodeNormal) |-> (hfOscEn && !sysClkSelLf));

  p_lf_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (oscCfg != LfCfgCode) |=> !lfOscEn);

  p_halt_sleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (haltStrobe && modeOut != CodeSleep) |=> (modeOut == CodeSleep && !hfOscEn));

  p_wdt_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (haltStrobe && modeOut != CodeSleep) |=> (wdtClear && wdtRun == $past(wdtSrcIndep)));

  p_no_clear_asleep_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdtClear |-> ($past(modeOut) != CodeSleep));

  p_sleep_hf_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == CodeSleep && $past(modeOut) == CodeSleep && !$past(wakeEvent)
     && !$past(hfOscEn)) |-> !hfOscEn);

  p_hf_before_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysClkSelLf) |-> $past(hfOscEn));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.CfgW(CfgW), .LfCfgCode(LfCfgCode)) chk_i (
  .clk(clk), .rstN(rstN), .oscCfg(oscCfg), .haltStrobe(haltStrobe),
  .wakeEvent(wakeEvent), .wdtSrcIndep(wdtSrcIndep), .hfOscEn(hfOscEn),
  .lfOscEn(lfOscEn), .sysClkSelLf(sysClkSelLf), .modeOut(modeOut),
  .wdtClear(wdtClear), .wdtRun(wdtRun)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] oscCfg = 2'd3;
  logic clkModeSlow = 1'b0, haltStrobe = 1'b0, wakeEvent = 1'b0, wdtSrcIndep = 1'b0;
  logic hfOscEn, lfOscEn, sysClkSelLf, wdtClear, wdtRun;
  logic [1:0] modeOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // reference model state
  int mMode, mHf, mSel, mLf, mClr, mRun, mPhase, mTgt;

  always #(ClkPeriod/2) clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rstN(rstN), .oscCfg(oscCfg), .clkModeSlow(clkModeSlow),
    .haltStrobe(haltStrobe), .wakeEvent(wakeEvent), .wdtSrcIndep(wdtSrcIndep),
    .hfOscEn(hfOscEn), .lfOscEn(lfOscEn), .sysClkSelLf(sysClkSelLf),
    .modeOut(modeOut), .wdtClear(wdtClear), .wdtRun(wdtRun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mHf = 1; mSel = 0; mLf = 0; mClr = 1; mRun = 1; mPhase = 0; mTgt = 0;
  endtask

  // advance the model by one clock edge from the inputs held at that edge
  task automatic modelEdge();
    bit wantSlow;
    wantSlow = (oscCfg == 2'd3) && clkModeSlow;
    mLf  = (oscCfg == 2'd3);
    mClr = 0;
    if (mMode != 2) begin
      if (haltStrobe) begin
        mMode = 2; mHf = 0; mClr = 1; mRun = int'(wdtSrcIndep); mPhase = 0;
      end else if (mPhase == 1) begin
        mMode = 0; mSel = 0; mPhase = 0;
      end else if (mMode == 0 && wantSlow) begin
        mMode = 1; mSel = 1; mHf = 0;
      end else if (mMode == 1 && !wantSlow) begin
        mHf = 1; mPhase = 1;
      end
    end else if (mPhase == 2) begin
      mMode = mTgt ? 1 : 0; mSel = mTgt; mHf = mTgt ? 0 : 1; mRun = 1; mPhase = 0;
    end else if (wakeEvent) begin
      mHf = 1; mPhase = 2; mTgt = int'(wantSlow);
    end
  endtask

  task automatic compareAll();
    chk("R4 modeOut", int'(modeOut), mMode);
    chk("R8 hfOscEn", int'(hfOscEn), mHf);
    chk("R9 sysClkSelLf", int'(sysClkSelLf), mSel);
    chk("R3 lfOscEn", int'(lfOscEn), mLf);
    chk("R6 wdtClear", int'(wdtClear), mClr);
    chk("R6 wdtRun", int'(wdtRun), mRun);
  endtask

  task automatic step(input logic [1:0] cfg, input logic cm, input logic halt,
                      input logic wake, input logic src);
    oscCfg = cfg; clkModeSlow = cm; haltStrobe = halt; wakeEvent = wake; wdtSrcIndep = src;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 mode", int'(modeOut), 0);
    chk("R10 hf", int'(hfOscEn), 1);
    chk("R10 sel", int'(sysClkSelLf), 0);
    chk("R10 lf", int'(lfOscEn), 0);
    chk("R10 clear", int'(wdtClear), 1);
    chk("R10 run", int'(wdtRun), 1);
    rstN = 1'b1;

    // R1: Normal holds
    repeat (3) step(2'd3, 0, 0, 0, 0);
    chk("R1 mode normal", int'(modeOut), 0);
    chk("R1 hf on", int'(hfOscEn), 1);

    // R2: enter Slow
    step(2'd3, 1, 0, 0, 0);
    chk("R2 slow mode", int'(modeOut), 1);
    chk("R2 sel lf", int'(sysClkSelLf), 1);
    chk("R2 hf off", int'(hfOscEn), 0);
    step(2'd3, 1, 0, 0, 0);

    // R9: back to Normal in two edges
    step(2'd3, 0, 0, 0, 0);
    chk("R9 hf first", int'(hfOscEn), 1);
    chk("R9 sel still lf", int'(sysClkSelLf), 1);
    step(2'd3, 0, 0, 0, 0);
    chk("R9 sel released", int'(sysClkSelLf), 0);
    chk("R9 mode normal", int'(modeOut), 0);

    // R2, R3: other option ignores clock-mode bit
    repeat (3) step(2'd0, 1, 0, 0, 0);
    chk("R2 inert bit", int'(modeOut), 0);
    chk("R3 lf off", int'(lfOscEn), 0);

    // R6: halt with independent watchdog clock
    step(2'd3, 0, 0, 0, 1);
    step(2'd3, 0, 1, 0, 1);
    chk("R4 sleep", int'(modeOut), 2);
    chk("R6 clear pulse", int'(wdtClear), 1);
    chk("R6 run kept", int'(wdtRun), 1);
    step(2'd3, 0, 0, 0, 0);
    chk("R6 pulse one cycle", int'(wdtClear), 0);
    // R7: halt in Sleep ignored
    step(2'd3, 0, 1, 0, 0);
    chk("R7 no clear", int'(wdtClear), 0);
    chk("R7 still sleep", int'(modeOut), 2);
    // R5: crystal on in Sleep, clock-mode change while asleep
    step(2'd3, 1, 0, 0, 0);
    chk("R5 lf on", int'(lfOscEn), 1);
    chk("R5 sel held", int'(sysClkSelLf), 0);
    // R8: wake to Slow
    step(2'd3, 1, 0, 1, 0);
    chk("R8 hf up", int'(hfOscEn), 1);
    chk("R8 still sleep", int'(modeOut), 2);
    step(2'd3, 1, 0, 0, 0);
    chk("R8 slow", int'(modeOut), 1);

    // R4: halt beats clock-mode change, watchdog on system clock
    step(2'd3, 0, 1, 0, 0);
    chk("R4 halt priority", int'(modeOut), 2);
    chk("R6 run stops", int'(wdtRun), 0);
    repeat (2) step(2'd3, 0, 0, 0, 1);
    chk("R6 run held", int'(wdtRun), 0);
    chk("R5 sel held lf", int'(sysClkSelLf), 1);
    step(2'd3, 0, 0, 1, 0);
    step(2'd3, 0, 0, 0, 0);
    chk("R8 normal", int'(modeOut), 0);
    chk("R6 run restored", int'(wdtRun), 1);

    // halt during the two-step return from Slow
    step(2'd3, 1, 0, 0, 0);
    step(2'd3, 0, 0, 0, 0);
    step(2'd3, 0, 1, 0, 1);
    chk("R4 halt mid switch", int'(modeOut), 2);
    step(2'd3, 0, 0, 1, 0);
    step(2'd3, 0, 0, 0, 0);
    chk("R9 wake release", int'(sysClkSelLf), 0);

    // option 1: halt and wake without crystal
    step(2'd1, 1, 1, 0, 0);
    step(2'd1, 1, 0, 0, 0);
    chk("R3 no crystal asleep", int'(lfOscEn), 0);
    step(2'd1, 1, 0, 1, 0);
    step(2'd1, 1, 0, 0, 0);
    chk("R8 normal only", int'(modeOut), 0);
    repeat (2) step(2'd1, 0, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule